// File: doc/BRIEF.md
# AGC Update-Sync Hold-Off Controller

This block decides when a gain-control loop gets a new update sample and whether that update also re-initializes the loop. A sync request can come from a pin or from software. Either one arms a loadable down-counter. When the delay runs out, the block emits a one-cycle dump strobe to the averaging decimator. If re-initialization is enabled, the same cycle also carries a clear strobe and a parameter-load strobe.

A control byte selects several options:
- re-initialize on every internal sync;
- honour only the first sync and run freely after it;
- bypass the loop entirely;
- a self-clearing command that forces an update at once.

The block also owns the output truncation stage. It cuts the wide loop data down to a selectable output word length, so the truncated word exists whether or not the loop is bypassed.

A hold-off value of N gives a dump N cycles after the sync, counted from the sync edge. A value of 1 therefore responds straight away, and a value of 0 shuts sync-driven updates off.

Top module: `agc_sync_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `dump_o`, `clear_o`, `load_o`, `loop_bypass_o` and `data_o` are 0. The reset state has the hold-off value 0, all control options off, the width code 0 and the first-sync latch cleared.
- R2: A sync on `pin_sync_i` or `soft_sync_i` with hold-off value N≥1 gives exactly one `dump_o` pulse, one cycle long. It is high after the (N−1)th rising edge that follows the edge sampling the sync (N=1: directly after that edge).
- R3: With hold-off value 0, syncs never produce `dump_o`.
- R4: A sync that arrives while a countdown is running reloads the counter. Only one dump results, timed from the latest sync.
- R5: Control bit 1 (init) set: `clear_o` and `load_o` pulse together with every `dump_o`. Bit clear: they stay low while `dump_o` still pulses.
- R6: Control bit 2 (ignore-repeat) set: only the first accepted sync produces a dump and later syncs are discarded. Writing the bit to 0 clears the latch, and setting it again re-arms it.
- R7: A control write with bit 0 (immediate) set gives `dump_o` high directly after the edge that follows the write edge. This happens even with hold-off 0. The bit self-clears, so later writes without it cause no dump.
- R8: Control bit 3 (bypass) set drives `loop_bypass_o` high one edge after the write. From the cycle after that, no dump, clear or load strobe is produced, from either syncs or the immediate command.
- R9: `data_o` is registered, one edge after `data_i`. It holds the top W bits of `data_i`, sign-extended to 16 bits. W is selected by control bits 6:4: code 0→4, 1→5, 2→6, 3→7, 4→8, 5→10, 6→12, 7→16.
- R10: An immediate command and a countdown expiry in the same cycle merge into a single one-cycle dump (with clear and load if init is set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sync_i | input | 1 | Sync pulse from the pin path, single cycle |
| soft_sync_i | input | 1 | Sync pulse from software, single cycle |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 7 | Control value: 0 immediate, 1 init, 2 ignore-repeat, 3 bypass, 6:4 width code |
| hold_we_i | input | 1 | Hold-off value write strobe |
| hold_wdata_i | input | CW (8) | Hold-off value |
| data_i | input | DW (23) | Wide loop data to truncate |
| dump_o | output | 1 | Update-sample strobe to the decimator |
| clear_o | output | 1 | Decimator clear strobe |
| load_o | output | 1 | Loop parameter load strobe |
| loop_bypass_o | output | 1 | Gain loop disabled |
| data_o | output | OW (16) | Truncated, sign-extended output word |

## Verification
The immediate command and the expiry of a running countdown can both want to issue an update in the same cycle. The bench sets a hold-off of 3 and raises a pin sync. It then writes the immediate bit, with init set, on the edge after the sync, so that the pending immediate request and the counter reaching one meet in the same cycle. The result passes only if exactly one dump pulse appears, with clear and load beside it, and the following cycles stay quiet.

// File: rtl/agc_sync_pkg.sv
`timescale 1ns/1ps
package agc_sync_pkg;

  // control byte bit positions
  localparam int CB_IMM    = 0;
  localparam int CB_INIT   = 1;
  localparam int CB_IGNORE = 2;
  localparam int CB_BYPASS = 3;
  localparam int CB_WSEL   = 4;

  typedef struct packed {
    logic [2:0] wsel;
    logic       bypass;
    logic       ignore_rep;
    logic       init_en;
  } agc_cfg_t;

  // output word length for each width code
  function automatic int word_len(input logic [2:0] code);
    case (code)
      3'd0:    return 4;
      3'd1:    return 5;
      3'd2:    return 6;
      3'd3:    return 7;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/agc_sync_cfg.sv
`timescale 1ns/1ps
module agc_sync_cfg
  import agc_sync_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [6:0]    ctrl_wdata,
  input  logic          hold_we,
  input  logic [CW-1:0] hold_wdata,
  output agc_cfg_t      cfg_q,
  output logic [CW-1:0] hold_q,
  output logic          imm_pend
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      hold_q   <= '0;
      imm_pend <= 1'b0;
    end else begin
      // immediate command lives for one cycle only
      imm_pend <= ctrl_we & ctrl_wdata[CB_IMM];
      if (ctrl_we) begin
        cfg_q.init_en    <= ctrl_wdata[CB_INIT];
        cfg_q.ignore_rep <= ctrl_wdata[CB_IGNORE];
        cfg_q.bypass     <= ctrl_wdata[CB_BYPASS];
        cfg_q.wsel       <= ctrl_wdata[CB_WSEL +: 3];
      end
      if (hold_we) hold_q <= hold_wdata;
    end
  end

endmodule

// File: rtl/agc_sync_holdoff.sv
`timescale 1ns/1ps
module agc_sync_holdoff #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_req,
  input  logic          enable,
  input  logic          ignore_rep,
  input  logic [CW-1:0] hold_q,
  input  logic          imm_pend,
  output logic          accept,
  output logic          fire,
  output logic          cnt_idle
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          cnt_fire;

  always_comb begin
    accept   = sync_req && enable && (hold_q != '0) && !(ignore_rep && first_q);
    // a fresh sync restarts the delay and overrides an expiring count
    cnt_fire = !accept && (cnt_q == ONE);
    fire     = enable && (imm_pend || cnt_fire || (accept && hold_q == ONE));
    cnt_idle = (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (!enable)            cnt_q <= '0;
      else if (accept)        cnt_q <= hold_q - ONE;
      else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;

      if (!ignore_rep)        first_q <= 1'b0;
      else if (accept)        first_q <= 1'b1;
    end
  end

endmodule

// File: rtl/agc_sync_strobe.sv
`timescale 1ns/1ps
module agc_sync_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic init_en,
  output logic dump_o,
  output logic clear_o,
  output logic load_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dump_o  <= 1'b0;
      clear_o <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      dump_o  <= fire;
      clear_o <= fire & init_en;
      load_o  <= fire & init_en;
    end
  end

endmodule

// File: rtl/agc_sync_trunc.sv
`timescale 1ns/1ps
module agc_sync_trunc
  import agc_sync_pkg::*;
#(
  parameter int DW = 23,  // must be at least 16
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    wsel,
  input  logic [DW-1:0] data_i,
  output logic [OW-1:0] data_o
);

  int          shamt;
  logic [OW-1:0] data_d;

  always_comb begin
    shamt  = DW - word_len(wsel);
    data_d = OW'($signed(data_i) >>> shamt);
  end

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= data_d;
  end

endmodule

// File: rtl/agc_sync_ctrl.sv
`timescale 1ns/1ps
module agc_sync_ctrl
  import agc_sync_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 23,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_sync_i,
  input  logic          soft_sync_i,
  input  logic          ctrl_we_i,
  input  logic [6:0]    ctrl_wdata_i,
  input  logic          hold_we_i,
  input  logic [CW-1:0] hold_wdata_i,
  input  logic [DW-1:0] data_i,
  output logic          dump_o,
  output logic          clear_o,
  output logic          load_o,
  output logic          loop_bypass_o,
  output logic [OW-1:0] data_o
);

  agc_cfg_t      cfg_q;
  logic [CW-1:0] hold_q;
  logic          imm_pend;
  logic          init_en;
  logic          accept;
  logic          fire;
  logic          cnt_idle;

  assign init_en       = cfg_q.init_en;
  assign loop_bypass_o = cfg_q.bypass;

  agc_sync_cfg #(.CW(CW)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we_i),
    .ctrl_wdata (ctrl_wdata_i),
    .hold_we    (hold_we_i),
    .hold_wdata (hold_wdata_i),
    .cfg_q      (cfg_q),
    .hold_q     (hold_q),
    .imm_pend   (imm_pend)
  );

  agc_sync_holdoff #(.CW(CW)) u_holdoff (
    .clk        (clk),
    .rst        (rst),
    .sync_req   (pin_sync_i | soft_sync_i),
    .enable     (!cfg_q.bypass),
    .ignore_rep (cfg_q.ignore_rep),
    .hold_q     (hold_q),
    .imm_pend   (imm_pend),
    .accept     (accept),
    .fire       (fire),
    .cnt_idle   (cnt_idle)
  );

  agc_sync_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .init_en (init_en),
    .dump_o  (dump_o),
    .clear_o (clear_o),
    .load_o  (load_o)
  );

  agc_sync_trunc #(.DW(DW), .OW(OW)) u_trunc (
    .clk    (clk),
    .rst    (rst),
    .wsel   (cfg_q.wsel),
    .data_i (data_i),
    .data_o (data_o)
  );

endmodule

// File: rtl/agc_sync_chk.sv
`timescale 1ns/1ps
module agc_sync_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dump_o,
  input logic          clear_o,
  input logic          load_o,
  input logic          loop_bypass_o,
  input logic          init_en,
  input logic [CW-1:0] hold_q,
  input logic          imm_pend,
  input logic          accept,
  input logic          cnt_idle
);

  // R5
  clear_needs_dump_chk: assert property (@(posedge clk) disable iff (rst)
    clear_o |-> dump_o);

  // R5
  load_tracks_init_chk: assert property (@(posedge clk) disable iff (rst)
    dump_o |-> (load_o == $past(init_en)));

  // R8
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_bypass_o && $past(loop_bypass_o)) |-> !dump_o);

  // R2
  unit_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && hold_q == CW'(1)) |=> dump_o);

  // R3
  zero_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_q) == '0 && $past(cnt_idle) && !$past(imm_pend)) |-> !dump_o);

  // R7
  immediate_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (imm_pend && !loop_bypass_o) |=> dump_o);

endmodule

bind agc_sync_ctrl agc_sync_chk #(.CW(CW)) u_agc_sync_chk (
  .clk           (clk),
  .rst           (rst),
  .dump_o        (dump_o),
  .clear_o       (clear_o),
  .load_o        (load_o),
  .loop_bypass_o (loop_bypass_o),
  .init_en       (init_en),
  .hold_q        (hold_q),
  .imm_pend      (imm_pend),
  .accept        (accept),
  .cnt_idle      (cnt_idle)
);

// File: tb/test_agc_sync_ctrl.sv
`timescale 1ns/1ps
module test_agc_sync_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_sync = 1'b0;
  logic        soft_sync = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [6:0]  ctrl_wdata = '0;
  logic        hold_we = 1'b0;
  logic [7:0]  hold_wdata = '0;
  logic [22:0] data_in = '0;
  logic        dump, clr, ld, byp;
  logic [15:0] data_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  agc_sync_ctrl i_agc_sync_ctrl (
    .clk           (clk),
    .rst           (rst),
    .pin_sync_i    (pin_sync),
    .soft_sync_i   (soft_sync),
    .ctrl_we_i     (ctrl_we),
    .ctrl_wdata_i  (ctrl_wdata),
    .hold_we_i     (hold_we),
    .hold_wdata_i  (hold_wdata),
    .data_i        (data_in),
    .dump_o        (dump),
    .clear_o       (clr),
    .load_o        (ld),
    .loop_bypass_o (byp),
    .data_o        (data_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [6:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    tick();
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic wr_hold(input logic [7:0] v);
    hold_we = 1'b1; hold_wdata = v;
    tick();
    hold_we = 1'b0; hold_wdata = '0;
  endtask

  // pulse a sync, then watch dump/clear/load over the window
  task automatic sync_expect(input int n, input bit use_pin, input bit exp_fire,
                             input bit exp_init, input string req);
    if (use_pin) pin_sync = 1'b1; else soft_sync = 1'b1;
    tick();
    pin_sync = 1'b0; soft_sync = 1'b0;
    for (int j = 0; j <= n + 2; j++) begin
      check({req, " dump"},  32'(dump), 32'(exp_fire && j == n - 1));
      check({req, " clear"}, 32'(clr),  32'(exp_fire && exp_init && j == n - 1));
      check({req, " load"},  32'(ld),   32'(exp_fire && exp_init && j == n - 1));
      tick();
    end
  endtask

  function automatic logic [15:0] exp_trunc(input logic [22:0] d, input logic [2:0] c);
    int w;
    logic [15:0] r;
    case (c)
      3'd0: w = 4;  3'd1: w = 5;  3'd2: w = 6;  3'd3: w = 7;
      3'd4: w = 8;  3'd5: w = 10; 3'd6: w = 12; default: w = 16;
    endcase
    for (int i = 0; i < 16; i++) r[i] = (i < w) ? d[23 - w + i] : d[22];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (4) tick();
    // R1 reset state while reset is held
    check("R1 dump",   32'(dump), 0);
    check("R1 clear",  32'(clr),  0);
    check("R1 load",   32'(ld),   0);
    check("R1 bypass", 32'(byp),  0);
    check("R1 data",   32'(data_out), 0);
    rst = 1'b0;
    tick();
    check("R1 dump after release", 32'(dump), 0);

    // R3 hold-off 0 from reset and written explicitly
    sync_expect(0, 1'b1, 1'b0, 1'b0, "R3");
    wr_hold(8'd0);
    sync_expect(0, 1'b0, 1'b0, 1'b0, "R3");

    // R2 directed and random delays
    wr_hold(8'd1);
    sync_expect(1, 1'b1, 1'b1, 1'b0, "R2 n1");
    wr_hold(8'd5);
    sync_expect(5, 1'b0, 1'b1, 1'b0, "R2 n5");
    for (int k = 0; k < 16; k++) begin
      int n;
      n = 1 + int'($urandom % 12);
      wr_hold(8'(n));
      sync_expect(n, bit'($urandom % 2), 1'b1, 1'b0, "R2 rand");
    end

    // R5 init strobes follow the init bit
    wr_ctrl(7'h02);
    wr_hold(8'd3);
    sync_expect(3, 1'b1, 1'b1, 1'b1, "R5 init");
    wr_ctrl(7'h00);
    sync_expect(3, 1'b0, 1'b1, 1'b0, "R5 noinit");

    // R4 reload: first sync at E0, second at E2, hold-off 4 -> dump after E5
    wr_hold(8'd4);
    pin_sync = 1'b1;
    tick();
    pin_sync = 1'b0;
    for (int j = 0; j <= 8; j++) begin
      check("R4 reload", 32'(dump), 32'(j == 5));
      pin_sync = (j == 1);
      tick();
    end
    pin_sync = 1'b0;

    // R6 ignore repeats, then re-arm
    wr_ctrl(7'h04);
    wr_hold(8'd2);
    sync_expect(2, 1'b1, 1'b1, 1'b0, "R6 first");
    sync_expect(2, 1'b1, 1'b0, 1'b0, "R6 repeat");
    sync_expect(2, 1'b0, 1'b0, 1'b0, "R6 repeat soft");
    wr_ctrl(7'h00);
    wr_ctrl(7'h04);
    sync_expect(2, 1'b1, 1'b1, 1'b0, "R6 rearmed");
    wr_ctrl(7'h00);

    // R7 immediate with hold-off 0, then self-clear
    wr_hold(8'd0);
    wr_ctrl(7'h01);
    check("R7 imm early", 32'(dump), 0);
    tick();
    check("R7 imm fire", 32'(dump), 1);
    tick();
    check("R7 imm single", 32'(dump), 0);
    wr_ctrl(7'h00);
    for (int j = 0; j < 3; j++) begin
      check("R7 self-clear", 32'(dump), 0);
      tick();
    end

    // R10 immediate meets countdown expiry in the same cycle
    wr_ctrl(7'h02);
    wr_hold(8'd3);
    pin_sync = 1'b1;
    tick();
    pin_sync = 1'b0;
    ctrl_we = 1'b1; ctrl_wdata = 7'h03;
    tick();
    ctrl_we = 1'b0; ctrl_wdata = '0;
    check("R10 before", 32'(dump), 0);
    tick();
    check("R10 dump",  32'(dump), 1);
    check("R10 clear", 32'(clr),  1);
    check("R10 load",  32'(ld),   1);
    tick();
    check("R10 single", 32'(dump), 0);
    tick();
    check("R10 quiet", 32'(dump), 0);

    // R8 bypass blocks syncs and immediate
    wr_ctrl(7'h08);
    check("R8 flag", 32'(byp), 1);
    wr_hold(8'd1);
    sync_expect(1, 1'b1, 1'b0, 1'b0, "R8 sync");
    wr_ctrl(7'h09);
    for (int j = 0; j < 3; j++) begin
      check("R8 imm", 32'(dump), 0);
      tick();
    end
    wr_ctrl(7'h00);
    check("R8 flag off", 32'(byp), 0);

    // R9 truncation: directed corners then random
    wr_ctrl({3'd7, 4'h0});
    data_in = 23'h400000;
    tick();
    check("R9 min16", 32'(data_out), 32'(exp_trunc(23'h400000, 3'd7)));
    wr_ctrl({3'd0, 4'h0});
    data_in = 23'h3FFFFF;
    tick();
    check("R9 max4", 32'(data_out), 32'(exp_trunc(23'h3FFFFF, 3'd0)));
    for (int k = 0; k < 30; k++) begin
      logic [2:0]  c;
      logic [22:0] d;
      c = 3'($urandom);
      d = 23'($urandom);
      wr_ctrl({c, 4'h0});
      data_in = d;
      tick();
      check("R9 rand", 32'(data_out), 32'(exp_trunc(d, c)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule